// File: doc/BRIEF.md
# Servo Signal Presence Qualifier

This block decides when a track-following servo loop may be switched on. A detector elsewhere produces a one-cycle strobe each time it sees a servo dibit. Each strobe reloads a short loss-of-signal timer, and a "signal present" flag stays high while that timer is running. A second, much longer arming timer runs only while the flag is high. When the arming timer has run its full length without a break, the servo enable rises.

If the strobes stop for longer than the short window, the flag falls. The enable falls with it in the same cycle, and the arming timer clears. A later recovery must then wait the full arming delay again. A single stray strobe lights the flag only for the short window. That window is far shorter than the arming delay, so noise spikes while the heads are unloaded never enable the servo.

Both timer lengths are parameters in clock cycles: `LOSS_CYC` for the loss window and `ARM_CYC` for the arming delay. At a 1 MHz clock the defaults of 50 and 3000 cycles give 50 µs and 3 ms.

Top module: `servo_presence_qual`

## Requirements
- R1: A strobe sampled high on `dibit_i` at a clock edge makes `present_o` high after that edge. `present_o` stays high for exactly `LOSS_CYC` edges counted from the last strobe edge, including that edge.
- R2: If `LOSS_CYC` edges pass with no strobe after the last strobe edge, `present_o` is low after the `LOSS_CYC`-th such edge. A gap of more than `LOSS_CYC` cycles between strobes therefore drops the flag.
- R3: While `present_o` is low, `servo_en_o` is low and the arming delay is held cleared. An isolated strobe never raises `servo_en_o`.
- R4: `servo_en_o` rises after the `ARM_CYC`-th edge following the edge at which `present_o` rose, provided `present_o` stays high throughout.
- R5: When `present_o` falls, `servo_en_o` falls after the same edge. A later recovery raises `servo_en_o` only after a full `ARM_CYC` edges again.
- R6: With no strobes at all, both outputs remain low indefinitely.
- R7: A synchronous active-high `rst_i` clears both timers. Both outputs are low after the reset edge.
- R8: A strobe that arrives while `present_o` is high restarts the full loss window, so strobes spaced exactly `LOSS_CYC` cycles apart keep `present_o` high without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dibit_i | input | 1 | One-cycle strobe per detected servo dibit |
| present_o | output | 1 | Servo signal present flag |
| servo_en_o | output | 1 | Enable for the track-following servo loop |

## Verification
A table of single strobes, each followed by an idle gap of a chosen length, separates the flag lasting one cycle too long from it lasting one cycle too short. The gaps sit just below, at and just above the loss window. A steady train of strobes spaced exactly one window apart checks both that retriggering works and that the enable rises on the exact arming edge and not one edge either side. Stopping the train then shows the enable falling together with the flag. A second train shows that the arming delay restarts from zero after a loss. A long silent run and an isolated spike confirm that noise alone never arms the servo.

// File: rtl/servo_qual_pkg.sv
package servo_qual_pkg;
  // bits needed to hold the values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sq_loss_timer.sv
module sq_loss_timer #(
  parameter int LOSS_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic present_o
);
  import servo_qual_pkg::*;
  localparam int LW = cnt_bits(LOSS_CYC);
  localparam logic [LW-1:0] RELOAD = LW'(LOSS_CYC);

  logic [LW-1:0] remain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)
      remain_q <= '0;
    else if (strobe_i)
      remain_q <= RELOAD;
    else if (remain_q != '0)
      remain_q <= remain_q - LW'(1);
  end

  assign present_o = (remain_q != '0);

  assert_strobe_sets_present_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |=> present_o);
  assert_fall_needs_idle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(present_o) |-> !$past(strobe_i));
  assert_retrigger_full_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |=> (remain_q == RELOAD));
endmodule

// File: rtl/sq_arm_timer.sv
module sq_arm_timer #(
  parameter int ARM_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic present_i,
  output logic armed_o
);
  import servo_qual_pkg::*;
  localparam int AW = cnt_bits(ARM_CYC);
  localparam logic [AW-1:0] FULL = AW'(ARM_CYC);

  logic [AW-1:0] elapsed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !present_i)
      elapsed_q <= '0;
    else if (elapsed_q != FULL)
      elapsed_q <= elapsed_q + AW'(1);
  end

  assign armed_o = (elapsed_q == FULL);

  assert_held_clear_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !present_i |=> !armed_o);
  assert_arm_sticks_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_o && present_i) |=> armed_o);
endmodule

// File: rtl/servo_presence_qual.sv
module servo_presence_qual #(
  parameter int LOSS_CYC = 50,
  parameter int ARM_CYC  = 3000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dibit_i,
  output logic present_o,
  output logic servo_en_o
);
  logic present;
  logic armed;

  sq_loss_timer #(.LOSS_CYC(LOSS_CYC)) u_loss (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .strobe_i  (dibit_i),
    .present_o (present)
  );

  sq_arm_timer #(.ARM_CYC(ARM_CYC)) u_arm (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .present_i (present),
    .armed_o   (armed)
  );

  // the flag gates the enable directly so a loss drops it in the same cycle
  assign present_o  = present;
  assign servo_en_o = present & armed;

  assert_en_needs_present_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    servo_en_o |-> present_o);
  assert_rise_after_present_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(servo_en_o) |-> $past(present_o));
  assert_drop_together_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(servo_en_o) && $fell(present_o)) |-> !servo_en_o);
  assert_reset_clears_R7: assert property (@(posedge clk_i)
    rst_i |=> (!present_o && !servo_en_o));
endmodule

// File: tb/sim_servo_presence_qual.sv
module sim_servo_presence_qual;
  localparam time CLK_PERIOD = 10ns;
  localparam int LOSS = 50;
  localparam int ARM  = 3000;
  localparam int NV   = 6;
  localparam int VEC_GAP [NV] = '{1, LOSS-1, LOSS, LOSS+1, 10, 2*LOSS};
  localparam bit VEC_EXP [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dibit = 1'b0;
  logic present, en;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  servo_presence_qual #(.LOSS_CYC(LOSS), .ARM_CYC(ARM)) u0 (
    .clk_i(clk), .rst_i(rst), .dibit_i(dibit),
    .present_o(present), .servo_en_o(en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  // drive for one cycle from a falling edge; return at the next falling edge
  task automatic cyc(input logic s);
    dibit = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  // strobe train spaced LOSS apart; checks enable at ARM-1 and ARM
  task automatic arm_train(input string req);
    for (int c = 0; c <= ARM + 5; c++) begin
      cyc((c % LOSS) == 0);
      if (c == ARM - 1) begin
        check({req, " en low one edge early"}, en, 1'b0);
        check("R8 present kept by spaced strobes", present, 1'b1);
      end
      if (c == ARM) check({req, " en high at arm edge"}, en, 1'b1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit bad;
    @(negedge clk); @(negedge clk);
    check("R7 reset present", present, 1'b0);
    check("R7 reset en", en, 1'b0);
    rst = 1'b0;

    // vector table: one strobe then an idle gap, expected flag
    for (int v = 0; v < NV; v++) begin
      cyc(1'b1);
      idle(VEC_GAP[v]);
      check(VEC_EXP[v] ? "R1 present held in window" : "R2 present dropped after window",
            present, VEC_EXP[v]);
      check("R3 en low for single strobe", en, 1'b0);
      idle(LOSS + 2);
    end

    // retrigger mid-window
    cyc(1'b1); idle(30); cyc(1'b1); idle(40);
    check("R8 retrigger restarts window", present, 1'b1);
    idle(LOSS);
    check("R2 present low after retriggered window", present, 1'b0);

    // silence
    bad = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      cyc(1'b0);
      if (present || en) bad = 1'b1;
    end
    check("R6 no strobes keeps outputs low", bad, 1'b0);

    // arming
    arm_train("R4");
    cyc(1'b1);
    idle(LOSS - 1);
    check("R5 en still high before loss", en, 1'b1);
    cyc(1'b0);
    check("R5 present falls", present, 1'b0);
    check("R5 en falls with present", en, 1'b0);

    // re-arm takes full delay again
    arm_train("R5 rearm");

    // reset while enabled
    rst = 1'b1; cyc(1'b0);
    check("R7 reset clears present", present, 1'b0);
    check("R7 reset clears en", en, 1'b0);
    rst = 1'b0;
    cyc(1'b1);
    check("R7 arm restarts after reset", en, 1'b0);

    // isolated spike after silence
    idle(LOSS + 2);
    bad = 1'b0;
    cyc(1'b1);
    for (int i = 0; i < 100; i++) begin
      cyc(1'b0);
      if (en) bad = 1'b1;
    end
    check("R3 isolated spike never enables", bad, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule